// File: doc/BRIEF.md
# Split-cycle multiplexed bus bridge

This bridge lets a processor with separate address and data buses, a Phi2 access clock and a single R/W line drive a peripheral that expects a shared address/data bus with an address latch enable, a write strobe and a read strobe. One access on the peripheral side becomes two processor accesses. First the processor writes the register number to an index location. Then it reads or writes a data location, and that second access fires the matching strobe.

The bridge is selected when address bits 15..1 match the base address shifted right by one. Address bit 0 chooses the index location (0) or the data location (1). The select signal, Phi2, R/W and A0 drive a single 3-to-8 active-low decode, and every strobe comes from that decode. For the data read, the shared bus is released and its value is passed to the processor. For the other two strobes, the bridge drives the processor's byte onto the shared bus. A shadow copy of the last index byte is kept in the bridge, so software can read the index back. Several data accesses can follow one index write.

Top module: `mux_bus_bridge`

## Requirements
- R1: After reset, an index read (match, A0=0, R/W=1, Phi2=1) returns 0 on rdata_o.
- R2: A matched write (R/W=0) with A0=0 and Phi2=1 holds ale_o high. No other access does so.
- R3: A matched write with A0=1 and Phi2=1 holds wr_no low. No other access does so.
- R4: A matched read (R/W=1) with A0=1 and Phi2=1 holds rd_no low, holds ad_oe_o low and puts ad_i on rdata_o.
- R5: While Phi2 is low, ale_o is 0, wr_no and rd_no are 1, and ad_oe_o is 0, whatever the other inputs are.
- R6: When address bits 15..1 do not equal BASE_ADDR bits 15..1, no strobe is active and ad_oe_o is 0.
- R7: An index read asserts no strobe and returns the byte latched by the most recent ALE cycle. Any access that is neither an index read nor a data read returns 0 on rdata_o.
- R8: ad_oe_o is high exactly during ALE and write-strobe cycles, and ad_o then equals data_i.
- R9: The shadow index is loaded from data_i on a clock edge only while ale_o is high. Data accesses, unmatched writes and Phi2-low cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the shadow index register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address |
| data_i | input | 8 | Processor write data |
| rw_i | input | 1 | 1 = read, 0 = write |
| phi2_i | input | 1 | Access phase, high during the data transfer |
| ad_i | input | 8 | Shared bus value driven by the peripheral |
| ale_o | output | 1 | Address latch enable, active high |
| wr_no | output | 1 | Write strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| ad_o | output | 8 | Byte the bridge drives onto the shared bus |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| rdata_o | output | 8 | Read data returned to the processor |

## Verification
The stimulus walks through all eight combinations of Phi2, R/W and A0 at the base address. These separate the three strobe lines from each other and from the silent index read. The same combinations are then repeated at addresses that differ from the base in bit 1 and in bit 15. This shows that the match uses every upper bit and never folds A0 into the match. Index write sequences with distinct bytes are followed by several data accesses, by unmatched writes and by Phi2-low writes. These show whether the shadow index loads only on a real ALE cycle and holds across repeated data accesses. Varying ad_i during reads shows whether the read path selects the peripheral bus, the shadow index or zero.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  // decode select is {phi2, rw, a0}
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned LINE_N  = 1 << SEL_W;
  localparam int unsigned LN_ALE  = 4;  // phi2=1 rw=0 a0=0
  localparam int unsigned LN_WR   = 5;  // phi2=1 rw=0 a0=1
  localparam int unsigned LN_IDXR = 6;  // phi2=1 rw=1 a0=0
  localparam int unsigned LN_RD   = 7;  // phi2=1 rw=1 a0=1
  typedef logic [LINE_N-1:0] line_vec_t;
endpackage

// File: rtl/addr_match.sv
module addr_match #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC100
) (
  input  logic [ADDR_W-1:1] addr_hi_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:1] BASE_HI = BASE_ADDR[ADDR_W-1:1];
  assign hit_o = (addr_hi_i == BASE_HI);
endmodule

// File: rtl/strobe_dec.sv
module strobe_dec
  import bridge_pkg::*;
(
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output line_vec_t        y_no
);
  for (genvar i = 0; i < LINE_N; i++) begin : g_line
    localparam logic [SEL_W-1:0] CODE = SEL_W'(i);
    assign y_no[i] = !(en_i && (sel_i == CODE));
  end
endmodule

// File: rtl/idx_shadow.sv
module idx_shadow #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge
  import bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rw_i,
  input  logic              phi2_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ale_o,
  output logic              wr_no,
  output logic              rd_no,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              hit;
  line_vec_t         line_n;
  logic [DATA_W-1:0] idx_q;

  addr_match #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_match (
    .addr_hi_i (addr_i[ADDR_W-1:1]),
    .hit_o     (hit)
  );

  strobe_dec u_dec (
    .en_i  (hit),
    .sel_i ({phi2_i, rw_i, addr_i[0]}),
    .y_no  (line_n)
  );

  idx_shadow #(.DATA_W(DATA_W)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (!line_n[LN_ALE]),
    .d_i    (data_i),
    .q_o    (idx_q)
  );

  assign ale_o   = !line_n[LN_ALE];
  assign wr_no   = line_n[LN_WR];
  assign rd_no   = line_n[LN_RD];
  assign ad_oe_o = !line_n[LN_ALE] || !line_n[LN_WR];
  assign ad_o    = data_i;

  always_comb begin
    if (!line_n[LN_RD])        rdata_o = ad_i;
    else if (!line_n[LN_IDXR]) rdata_o = idx_q;
    else                       rdata_o = '0;
  end
endmodule

// File: rtl/mux_bus_bridge_chk.sv
module mux_bus_bridge_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              rw_i,
  input logic              phi2_i,
  input logic [DATA_W-1:0] ad_i,
  input logic              ale_o,
  input logic              wr_no,
  input logic              rd_no,
  input logic [DATA_W-1:0] ad_o,
  input logic              ad_oe_o,
  input logic [DATA_W-1:0] rdata_o
);
  logic sel_ok, idx_rd;
  assign sel_ok = addr_i[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1];
  assign idx_rd = sel_ok && phi2_i && rw_i && !addr_i[0];

  assert_idle_phi2_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phi2_i |-> (!ale_o && wr_no && rd_no && !ad_oe_o));
  assert_one_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ale_o, !wr_no, !rd_no}));
  assert_no_hit_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ok |-> (!ale_o && wr_no && rd_no && !ad_oe_o));
  assert_no_drive_on_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (!ad_oe_o && rdata_o == ad_i));
  assert_drive_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (ad_o == data_i && (ale_o || !wr_no)));
  assert_wr_needs_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (!rw_i && addr_i[0] && phi2_i));
  assert_index_loaded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o ##1 idx_rd) |-> (rdata_o == $past(data_i)));
  assert_index_read_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_rd |-> (!ale_o && wr_no && rd_no));
endmodule

bind mux_bus_bridge mux_bus_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (.*);

// File: tb/tb_mux_bus_bridge.sv
module tb_mux_bus_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = 16'h0000;
  logic [7:0]  data_i = 8'h00;
  logic        rw_i = 1'b1;
  logic        phi2_i = 1'b0;
  logic [7:0]  ad_i = 8'h00;
  logic        ale_o, wr_no, rd_no, ad_oe_o;
  logic [7:0]  ad_o, rdata_o;

  int total = 0;
  int bad = 0;
  logic [7:0] m_idx = 8'h00;

  always #10 clk_i = !clk_i;  // 50 MHz

  mux_bus_bridge dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // one CPU cycle: drive after negedge, compare with model, advance model at posedge
  task automatic cyc(input string tag, input logic [15:0] a, input logic rw,
                     input logic p2, input logic [7:0] d, input logic [7:0] adv);
    logic hit, e_ale, e_wr, e_rd, e_idxr, e_oe;
    logic [7:0] e_rdata;
    @(negedge clk_i);
    addr_i = a; rw_i = rw; phi2_i = p2; data_i = d; ad_i = adv;
    hit     = (a[15:1] == 15'h6080);
    e_ale   = hit && p2 && !rw && !a[0];
    e_wr    = hit && p2 && !rw && a[0];
    e_rd    = hit && p2 && rw && a[0];
    e_idxr  = hit && p2 && rw && !a[0];
    e_oe    = e_ale || e_wr;
    e_rdata = e_rd ? adv : (e_idxr ? m_idx : 8'h00);
    #5;
    chk(ale_o == e_ale,  tag, "ale",   int'(ale_o), int'(e_ale));
    chk(wr_no == !e_wr,  tag, "wr_n",  int'(wr_no), int'(!e_wr));
    chk(rd_no == !e_rd,  tag, "rd_n",  int'(rd_no), int'(!e_rd));
    chk(ad_oe_o == e_oe, tag, "ad_oe", int'(ad_oe_o), int'(e_oe));
    if (e_oe) chk(ad_o == d, tag, "ad_o", int'(ad_o), int'(d));
    chk(rdata_o == e_rdata, tag, "rdata", int'(rdata_o), int'(e_rdata));
    @(posedge clk_i);
    if (e_ale) m_idx = d;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    cyc("R1", 16'hC100, 1'b1, 1'b1, 8'hAA, 8'h55);
    // R5 all combos with phi2 low
    for (int k = 0; k < 4; k++)
      cyc("R5", 16'hC100 | 16'(k & 1), logic'(k >> 1), 1'b0, 8'h3C, 8'hC3);
    // R2/R3/R4/R7 all combos at base with phi2 high
    cyc("R2", 16'hC100, 1'b0, 1'b1, 8'h12, 8'h00);
    cyc("R7", 16'hC100, 1'b1, 1'b1, 8'hFF, 8'h99);
    cyc("R3", 16'hC101, 1'b0, 1'b1, 8'h34, 8'h00);
    cyc("R4", 16'hC101, 1'b1, 1'b1, 8'h00, 8'h5A);
    cyc("R4", 16'hC101, 1'b1, 1'b1, 8'h00, 8'hA5);
    // R9 index held across repeated data accesses
    cyc("R9", 16'hC101, 1'b0, 1'b1, 8'h77, 8'h00);
    cyc("R9", 16'hC101, 1'b1, 1'b1, 8'h00, 8'h01);
    cyc("R9", 16'hC100, 1'b1, 1'b1, 8'h00, 8'h01);
    // R9 phi2-low write and unmatched write leave index alone
    cyc("R9", 16'hC100, 1'b0, 1'b0, 8'hEE, 8'h00);
    cyc("R9", 16'hC102, 1'b0, 1'b1, 8'hDD, 8'h00);
    cyc("R9", 16'hC100, 1'b1, 1'b1, 8'h00, 8'h00);
    // R6 mismatch in bit 1 and bit 15, all combos
    for (int k = 0; k < 4; k++) begin
      cyc("R6", 16'hC102 | 16'(k & 1), logic'(k >> 1), 1'b1, 8'h66, 8'h44);
      cyc("R6", 16'h4100 | 16'(k & 1), logic'(k >> 1), 1'b1, 8'h66, 8'h44);
    end
    // R8 drive on ALE and write strobe with distinct bytes
    for (int k = 0; k < 8; k++) begin
      cyc("R8", 16'hC100, 1'b0, 1'b1, 8'(8'h81 + k * 8'h13), 8'h00);
      cyc("R7", 16'hC100, 1'b1, 1'b1, 8'h00, 8'hF0);
      cyc("R8", 16'hC101, 1'b0, 1'b1, 8'(8'h0F ^ k), 8'h00);
    end
    // R7 other addresses return zero
    cyc("R7", 16'h0000, 1'b1, 1'b1, 8'h00, 8'hFF);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule